// File: doc/BRIEF.md
# Paged Byte Load-Store Unit

This unit is the data-memory port of a small 8-bit controller. Each access names a byte in a flat on-chip memory. The low eight address bits come from a general-purpose register value on `addr_lo`. The upper bits come from a separate page register value on `page`. Of the page input, only the bits that the configured memory size needs take part in the address. Any higher page bits have no effect.

A store writes its byte on the clock edge that ends the issuing cycle. A load reads memory on that same edge into an output register. The loaded byte and its write-back strobe therefore appear one cycle after the load was issued, so the instruction right after a load cannot use the result. The memory array starts with preset contents that are computed from two parameters, as a program image would supply them. The memory size is a parameter and may be any power of two from 1 KiB to 16 KiB.

Top module: `paged_lsu`

## Requirements
- R1: The byte address is formed from the low log2(MEM_BYTES)-8 bits of `page` as the upper bits and `addr_lo` as the lower 8 bits. Higher page bits are ignored, so with the default 1 KiB size, pages 6'b000001 and 6'b111101 select the same bytes.
- R2: When `st_en` is high at a rising edge, `st_data` is written to the addressed byte, and later loads of that byte return it.
- R3: A cycle with `ld_en` high and `st_en` low is a load. In the following cycle, `wb_en` is high and `ld_data` holds the addressed byte as it was at the load's edge.
- R4: `wb_en` is high only in the cycle right after a load. It is low after idle cycles and after store cycles.
- R5: Before any store, byte i holds (i*INIT_MUL + INIT_ADD) mod 256. The defaults are INIT_MUL=37 and INIT_ADD=11.
- R6: A load issued in the cycle right after a store to the same address returns the newly stored byte.
- R7: When `ld_en` and `st_en` are both high, only the store is performed, and `wb_en` stays low in the next cycle.
- R8: While `rst_n` is low, `wb_en` is 0 and `ld_data` is 8'h00.
- R9: `ld_data` changes only in cycles where `wb_en` is high. Otherwise it holds the last loaded byte, or 0 after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| ld_en | input | 1 | Load strobe for this cycle |
| st_en | input | 1 | Store strobe for this cycle |
| addr_lo | input | 8 | Low address byte from a general-purpose register |
| page | input | PAGE_W (6) | Page register value, supplies the upper address bits |
| st_data | input | 8 | Byte to store |
| ld_data | output | 8 | Loaded byte, valid while wb_en is high |
| wb_en | output | 1 | Write-back enable for the loaded byte |

## Verification
The assertions check the strobe timing on every cycle. A load must raise `wb_en` in the next cycle, and `wb_en` may never rise without a load before it. A cycle with both strobes must leave `wb_en` low, and `ld_data` must stay still whenever `wb_en` is low. The data itself can only be shown by the bench's scenarios, which compare against a byte model of the memory. Those scenarios cover the preset contents, the address formed across pages including ignored page bits, a store followed at once by a load, and the store-wins case.

// File: rtl/paged_lsu.sv
module paged_lsu #(
  parameter int MEM_BYTES = 1024,
  parameter int PAGE_W    = 6,
  parameter int INIT_MUL  = 37,
  parameter int INIT_ADD  = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_en,
  input  logic              st_en,
  input  logic [7:0]        addr_lo,
  input  logic [PAGE_W-1:0] page,
  input  logic [7:0]        st_data,
  output logic [7:0]        ld_data,
  output logic              wb_en
);
  localparam int AW = $clog2(MEM_BYTES);
  localparam int FW = PAGE_W + 8;

  logic [7:0]    mem [MEM_BYTES];
  logic [FW-1:0] full_addr;
  logic [AW-1:0] addr;
  logic          do_ld;

  assign full_addr = {page, addr_lo};
  assign addr      = full_addr[AW-1:0];
  assign do_ld     = ld_en & ~st_en;

  initial begin
    for (int i = 0; i < MEM_BYTES; i++)
      mem[i] = 8'((i * INIT_MUL + INIT_ADD) & 255);
  end

  always_ff @(posedge clk)
    if (st_en) mem[addr] <= st_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wb_en   <= 1'b0;
      ld_data <= 8'h00;
    end else begin
      wb_en <= do_ld;
      if (do_ld) ld_data <= mem[addr];
    end
  end
endmodule

module paged_lsu_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ld_en,
  input logic       st_en,
  input logic       wb_en,
  input logic [7:0] ld_data
);
  AST_WB_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_en && !st_en) |=> wb_en); // R3
  AST_WB_NEEDS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> $past(ld_en && !st_en)); // R4
  AST_STORE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_en && st_en) |=> !wb_en); // R7
  AST_DATA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!wb_en && $past(rst_n)) |-> $stable(ld_data)); // R9
  always @(posedge clk)
    if (!rst_n) AST_RESET_QUIET: assert (!wb_en && ld_data == 8'h00); // R8
endmodule

bind paged_lsu paged_lsu_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .st_en(st_en),
  .wb_en(wb_en), .ld_data(ld_data)
);

// File: tb/test_paged_lsu.sv
module test_paged_lsu;
  localparam int MEM_BYTES = 1024;
  localparam int PAGE_W    = 6;
  localparam int HI_W      = $clog2(MEM_BYTES) - 8;

  logic clk = 1'b0, rst_n = 1'b0, ld_en = 1'b0, st_en = 1'b0;
  logic [7:0] addr_lo = '0, st_data = '0;
  logic [PAGE_W-1:0] page = '0;
  logic [7:0] ld_data;
  logic wb_en;

  int total = 0, bad = 0;
  bit done = 0;
  logic [7:0] model [MEM_BYTES];
  logic [7:0] exp_q [$];
  string      tag_q [$];
  logic [7:0] last_val = 8'h00;

  always #5 clk = ~clk;

  paged_lsu #(.MEM_BYTES(MEM_BYTES), .PAGE_W(PAGE_W)) i_paged_lsu (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .st_en(st_en),
    .addr_lo(addr_lo), .page(page), .st_data(st_data),
    .ld_data(ld_data), .wb_en(wb_en)
  );

  function automatic int idx(logic [PAGE_W-1:0] pg, logic [7:0] lo);
    return int'(pg[HI_W-1:0]) * 256 + int'(lo);
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // driver: one cycle per call, inputs change 2 ns after the edge
  task automatic op(bit ld, bit st, logic [PAGE_W-1:0] pg, logic [7:0] lo,
                    logic [7:0] d, string tag);
    @(posedge clk); #2;
    ld_en = ld; st_en = st; page = pg; addr_lo = lo; st_data = d;
    if (ld && !st) begin
      exp_q.push_back(model[idx(pg, lo)]);
      tag_q.push_back(tag);
    end
    if (st) model[idx(pg, lo)] = d;
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) op(0, 0, '0, '0, '0, "");
  endtask

  // monitor: samples at the falling edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (wb_en) begin
        if (exp_q.size() == 0) check(0, "R4 unexpected wb_en", 1, 0);
        else begin
          logic [7:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(ld_data === e, t, ld_data, e);
          last_val = ld_data;
        end
      end else begin
        check(ld_data === last_val, "R9 hold", ld_data, last_val);
      end
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < MEM_BYTES; i++) model[i] = 8'((i * 37 + 11) & 255);
    #23;
    check(wb_en === 1'b0, "R8 wb_en in reset", wb_en, 0);
    check(ld_data === 8'h00, "R8 ld_data in reset", ld_data, 0);
    @(negedge clk); rst_n = 1'b1;
    idle(2);
    // R5 preset contents, across pages
    op(1, 0, 6'd0, 8'h00, 0, "R5 preset p0 0x00");
    op(1, 0, 6'd1, 8'h7f, 0, "R5 preset p1 0x7f");
    op(1, 0, 6'd3, 8'hff, 0, "R5 preset p3 0xff");
    idle(1);
    // R2 store then later load
    op(0, 1, 6'd2, 8'h10, 8'ha5, "");
    idle(2);
    op(1, 0, 6'd2, 8'h10, 0, "R2 stored byte");
    // R6 store followed at once by load
    op(0, 1, 6'd0, 8'h44, 8'h3c, "");
    op(1, 0, 6'd0, 8'h44, 0, "R6 store then load");
    idle(1);
    // R1 upper page bits ignored
    op(0, 1, 6'b111101, 8'h22, 8'h5a, "");
    op(1, 0, 6'b000001, 8'h22, 0, "R1 alias page");
    op(1, 0, 6'b101010, 8'h09, 0, "R1 alias read p2");
    idle(1);
    // R7 both strobes: store only, no write-back
    op(1, 1, 6'd3, 8'h01, 8'hc3, "");
    idle(2);
    op(1, 0, 6'd3, 8'h01, 0, "R7 store taken");
    // R3 back-to-back loads
    for (int k = 0; k < 8; k++) op(1, 0, 6'(k), 8'(k * 29), 0, "R3 burst load");
    idle(3);
    check(exp_q.size() == 0, "R3 all loads written back", exp_q.size(), 0);
    check(wb_en === 1'b0, "R4 idle wb_en low", wb_en, 0);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule